// File: doc/BRIEF.md
# SONET Overhead Status Monitor

This block watches a handful of received overhead bytes and turns them into alarm flags and remote error totals. An upstream framer that already knows where each overhead byte sits in the frame presents the byte on a shared data bus and raises the enable belonging to that byte position. The monitor samples only the bytes it is told about. Finding the bytes inside the frame is not part of this block.

Several indications come out of these bytes. The line maintenance byte yields line alarm indication and line remote defect. The two pointer bytes together yield path alarm indication. The path status byte yields path remote defect and a path remote error count. The line growth byte yields a line remote error count. Each remote error count is range-checked. Only legal counts are added into a saturating 16-bit total, and each of the two totals has its own counter.

The path signal label is compared against the ATM value 0x13. A mismatch that persists for three consecutive frames sets a latched interrupt, provided interrupts are enabled. A single frame that carries the expected label restarts the persistence count.

Top module: `sonet_oh_monitor`

## Requirements
- R1: On a cycle with `k2_en` high, `line_rdi` becomes 1 in the next cycle if bits [2:0] of `oh_byte` equal 3'b110, and 0 otherwise. It holds that value until the next `k2_en`.
- R2: On a cycle with `k2_en` high, `line_ais` becomes 1 in the next cycle if bits [2:0] of `oh_byte` equal 3'b111, and 0 otherwise. Bus values seen while `k2_en` is low have no effect.
- R3: `path_ais` updates on the cycle after `h2_en`. It is 1 only if the byte taken at the most recent `h1_en` and the byte at `h2_en` are both 0xFF.
- R4: On `g1_en`, `path_rdi` takes bit 3 of `oh_byte` in the next cycle.
- R5: Each `c2_en` byte not equal to 0x13 advances a mismatch count that saturates at 3, and a byte equal to 0x13 resets the count to 0. `label_irq` is set when a mismatch brings the count to 3 while `irq_en` is 1. With `irq_en` at 0 it is never set.
- R6: `label_irq` stays set until `irq_clr` is pulsed. If a set condition and `irq_clr` fall in the same cycle, the set wins.
- R7: On `z2_en`, the whole `oh_byte` is a count. Values 0 to 24 are added to `line_febe_cnt`, and values above 24 leave it unchanged.
- R8: On `g1_en`, bits [7:4] of `oh_byte` are a count. Values 0 to 8 are added to `path_febe_cnt`, and values 9 to 15 leave it unchanged.
- R9: Both error totals saturate at 65535 and do not wrap.
- R10: `febe_clr` zeroes both totals in the next cycle. If a legal count arrives in the same cycle, the total becomes that count.
- R11: After reset, all flags, the interrupt and both totals are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oh_byte | input | 8 | Received overhead byte |
| k2_en | input | 1 | Line maintenance byte present |
| h1_en | input | 1 | First pointer byte present |
| h2_en | input | 1 | Second pointer byte present |
| c2_en | input | 1 | Path signal label present |
| z2_en | input | 1 | Line remote error byte present |
| g1_en | input | 1 | Path status byte present |
| irq_en | input | 1 | Allows the label interrupt to be set |
| irq_clr | input | 1 | Clears the label interrupt |
| febe_clr | input | 1 | Clears both error totals |
| line_ais | output | 1 | Line alarm indication |
| line_rdi | output | 1 | Line remote defect |
| path_ais | output | 1 | Path alarm indication |
| path_rdi | output | 1 | Path remote defect |
| label_irq | output | 1 | Latched label mismatch interrupt |
| line_febe_cnt | output | 16 | Line remote error total |
| path_febe_cnt | output | 16 | Path remote error total |

## Verification
Two collisions are provoked on purpose. The first is a clear strobe that arrives in the same cycle as a legal error count. The bench pulses `febe_clr` together with a line count of 5 and expects the line total to read exactly 5 and the path total to read 0. The second is an interrupt clear that arrives in the same cycle as a persisting label mismatch. Here the bench expects `label_irq` to remain 1, and then expects a lone `irq_clr` to drop it.

// File: rtl/sonet_ohm_pkg.sv
package sonet_ohm_pkg;

    localparam logic [7:0] ATM_LABEL   = 8'h13;
    localparam logic [2:0] K2_RDI_CODE = 3'b110;
    localparam logic [2:0] K2_AIS_CODE = 3'b111;
    localparam logic [7:0] ALL_ONES    = 8'hFF;

    typedef struct packed {
        logic line_ais;
        logic line_rdi;
        logic path_ais;
        logic path_rdi;
    } defect_t;

    typedef struct packed {
        logic k2;
        logic h1;
        logic h2;
        logic c2;
        logic z2;
        logic g1;
    } oh_sel_t;

    function automatic logic k2_is(input logic [7:0] b, input logic [2:0] code);
        return b[2:0] == code;
    endfunction

endpackage

// File: rtl/ohm_defect_track.sv
module ohm_defect_track
    import sonet_ohm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  oh_sel_t     sel,
    input  logic [7:0]  data,
    output defect_t     status
);
    logic    h1_ones_q;
    defect_t stat_q;
    defect_t stat_d;
    logic    h1_ones_d;

    always_comb begin
        stat_d    = stat_q;
        h1_ones_d = h1_ones_q;
        if (sel.k2) begin
            stat_d.line_rdi = k2_is(data, K2_RDI_CODE);
            stat_d.line_ais = k2_is(data, K2_AIS_CODE);
        end
        if (sel.h1) h1_ones_d = (data == ALL_ONES);
        if (sel.h2) stat_d.path_ais = h1_ones_q && (data == ALL_ONES);
        if (sel.g1) stat_d.path_rdi = data[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            h1_ones_q <= 1'b0;
        end else begin
            stat_q    <= stat_d;
            h1_ones_q <= h1_ones_d;
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/ohm_label_watch.sv
module ohm_label_watch #(
    parameter int         PERSIST  = 3,
    parameter logic [7:0] EXPECTED = 8'h13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic [7:0] data,
    input  logic       irq_en,
    input  logic       irq_clr,
    output logic       irq
);
    localparam int PW = $clog2(PERSIST + 1);
    localparam logic [PW-1:0] TOP = PW'(PERSIST);

    logic [PW-1:0] miss_q, miss_d;
    logic          irq_q, set_irq;

    always_comb begin
        miss_d  = miss_q;
        set_irq = 1'b0;
        if (valid) begin
            if (data == EXPECTED) begin
                miss_d = '0;
            end else begin
                miss_d  = (miss_q == TOP) ? miss_q : miss_q + 1'b1;
                set_irq = irq_en && (miss_d == TOP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            miss_q <= miss_d;
            if (set_irq)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/ohm_febe_acc.sv
module ohm_febe_acc #(
    parameter int CNT_W   = 16,
    parameter int FIELD_W = 8,
    parameter int LIMIT   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               valid,
    input  logic [FIELD_W-1:0] count_in,
    output logic [CNT_W-1:0]   total
);
    localparam logic [CNT_W:0] SAT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] tot_q, base, tot_d;
    logic [CNT_W:0]   sum;
    logic             legal;

    always_comb begin
        base  = clr ? '0 : tot_q;
        legal = count_in <= FIELD_W'(LIMIT);
        sum   = {1'b0, base} + (CNT_W+1)'(count_in);
        if (valid && legal)
            tot_d = (sum > SAT) ? SAT[CNT_W-1:0] : sum[CNT_W-1:0];
        else
            tot_d = base;
    end

    always_ff @(posedge clk) begin
        if (rst) tot_q <= '0;
        else     tot_q <= tot_d;
    end

    assign total = tot_q;
endmodule

// File: rtl/sonet_oh_monitor.sv
module sonet_oh_monitor
    import sonet_ohm_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LINE_LIMIT = 24,
    parameter int PATH_LIMIT = 8,
    parameter int PERSIST    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       oh_byte,
    input  logic             k2_en,
    input  logic             h1_en,
    input  logic             h2_en,
    input  logic             c2_en,
    input  logic             z2_en,
    input  logic             g1_en,
    input  logic             irq_en,
    input  logic             irq_clr,
    input  logic             febe_clr,
    output logic             line_ais,
    output logic             line_rdi,
    output logic             path_ais,
    output logic             path_rdi,
    output logic             label_irq,
    output logic [CNT_W-1:0] line_febe_cnt,
    output logic [CNT_W-1:0] path_febe_cnt
);
    oh_sel_t sel;
    defect_t status;

    assign sel = '{k2: k2_en, h1: h1_en, h2: h2_en, c2: c2_en, z2: z2_en, g1: g1_en};

    ohm_defect_track u_defect (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .data   (oh_byte),
        .status (status)
    );

    ohm_label_watch #(.PERSIST(PERSIST), .EXPECTED(ATM_LABEL)) u_label (
        .clk     (clk),
        .rst     (rst),
        .valid   (sel.c2),
        .data    (oh_byte),
        .irq_en  (irq_en),
        .irq_clr (irq_clr),
        .irq     (label_irq)
    );

    ohm_febe_acc #(.CNT_W(CNT_W), .FIELD_W(8), .LIMIT(LINE_LIMIT)) u_line_febe (
        .clk      (clk),
        .rst      (rst),
        .clr      (febe_clr),
        .valid    (sel.z2),
        .count_in (oh_byte),
        .total    (line_febe_cnt)
    );

    ohm_febe_acc #(.CNT_W(CNT_W), .FIELD_W(4), .LIMIT(PATH_LIMIT)) u_path_febe (
        .clk      (clk),
        .rst      (rst),
        .clr      (febe_clr),
        .valid    (sel.g1),
        .count_in (oh_byte[7:4]),
        .total    (path_febe_cnt)
    );

    assign line_ais = status.line_ais;
    assign line_rdi = status.line_rdi;
    assign path_ais = status.path_ais;
    assign path_rdi = status.path_rdi;
endmodule

// File: rtl/ohm_checker.sv
module ohm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       oh_byte,
    input logic             k2_en,
    input logic             z2_en,
    input logic             g1_en,
    input logic             irq_clr,
    input logic             febe_clr,
    input logic             line_ais,
    input logic             line_rdi,
    input logic             label_irq,
    input logic [CNT_W-1:0] line_febe_cnt,
    input logic [CNT_W-1:0] path_febe_cnt
);
    // R1
    rdi_ais_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_ais && line_rdi));

    // R2
    line_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !k2_en |=> ($stable(line_ais) && $stable(line_rdi)));

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (label_irq && !irq_clr) |=> label_irq);

    // R7
    line_illegal_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (z2_en && oh_byte > 8'd24 && !febe_clr) |=> $stable(line_febe_cnt));

    // R8
    path_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!g1_en && !febe_clr) |=> $stable(path_febe_cnt));

    // R9
    line_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !febe_clr |=> line_febe_cnt >= $past(line_febe_cnt));

    // R9
    path_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !febe_clr |=> path_febe_cnt >= $past(path_febe_cnt));
endmodule

bind sonet_oh_monitor ohm_checker #(.CNT_W(CNT_W)) u_ohm_chk (
    .clk           (clk),
    .rst           (rst),
    .oh_byte       (oh_byte),
    .k2_en         (k2_en),
    .z2_en         (z2_en),
    .g1_en         (g1_en),
    .irq_clr       (irq_clr),
    .febe_clr      (febe_clr),
    .line_ais      (line_ais),
    .line_rdi      (line_rdi),
    .label_irq     (label_irq),
    .line_febe_cnt (line_febe_cnt),
    .path_febe_cnt (path_febe_cnt)
);

// File: tb/sonet_oh_monitor_test.sv
module sonet_oh_monitor_test;

    localparam int SIG_LAIS = 0, SIG_LRDI = 1, SIG_PAIS = 2, SIG_PRDI = 3,
                   SIG_IRQ = 4, SIG_LCNT = 5, SIG_PCNT = 6;

    typedef struct {
        string req;
        int    sig;
        int    exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  oh_byte = '0;
    logic        k2_en = 0, h1_en = 0, h2_en = 0, c2_en = 0, z2_en = 0, g1_en = 0;
    logic        irq_en = 0, irq_clr = 0, febe_clr = 0;
    logic        line_ais, line_rdi, path_ais, path_rdi, label_irq;
    logic [15:0] line_febe_cnt, path_febe_cnt;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    always #2 clk = ~clk;

    sonet_oh_monitor uut (
        .clk(clk), .rst(rst), .oh_byte(oh_byte),
        .k2_en(k2_en), .h1_en(h1_en), .h2_en(h2_en), .c2_en(c2_en),
        .z2_en(z2_en), .g1_en(g1_en), .irq_en(irq_en), .irq_clr(irq_clr),
        .febe_clr(febe_clr), .line_ais(line_ais), .line_rdi(line_rdi),
        .path_ais(path_ais), .path_rdi(path_rdi), .label_irq(label_irq),
        .line_febe_cnt(line_febe_cnt), .path_febe_cnt(path_febe_cnt)
    );

    function automatic int observe(input int sig);
        case (sig)
            SIG_LAIS: return int'(line_ais);
            SIG_LRDI: return int'(line_rdi);
            SIG_PAIS: return int'(path_ais);
            SIG_PRDI: return int'(path_rdi);
            SIG_IRQ:  return int'(label_irq);
            SIG_LCNT: return int'(line_febe_cnt);
            default:  return int'(path_febe_cnt);
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int    act;
            it  = sb.pop_front();
            act = observe(it.sig);
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s signal %0d actual %0d expected %0d",
                         it.req, it.sig, act, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int sig, input int exp);
        item_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        sb.push_back(it);
    endtask

    // driver: one cycle of stimulus, enables vector {k2,h1,h2,c2,z2,g1}
    task automatic drive(input logic [5:0] ens, input logic [7:0] b,
                         input logic iclr, input logic fclr);
        @(negedge clk);
        {k2_en, h1_en, h2_en, c2_en, z2_en, g1_en} = ens;
        oh_byte  = b;
        irq_clr  = iclr;
        febe_clr = fclr;
        @(posedge clk);
        #1;
        {k2_en, h1_en, h2_en, c2_en, z2_en, g1_en} = '0;
        irq_clr  = 0;
        febe_clr = 0;
    endtask

    localparam logic [5:0] E_K2 = 6'b100000, E_H1 = 6'b010000, E_H2 = 6'b001000,
                           E_C2 = 6'b000100, E_Z2 = 6'b000010, E_G1 = 6'b000001;

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset state
        for (int s = 0; s <= SIG_PCNT; s++) expect_val("R11", s, 0);
        @(negedge clk);

        // R1 / R2 line status
        drive(E_K2, 8'h06, 0, 0);
        expect_val("R1", SIG_LRDI, 1); expect_val("R2", SIG_LAIS, 0);
        drive(E_K2, 8'h07, 0, 0);
        expect_val("R2", SIG_LAIS, 1); expect_val("R1", SIG_LRDI, 0);
        drive(6'b0, 8'h06, 0, 0);
        expect_val("R2", SIG_LAIS, 1); expect_val("R1", SIG_LRDI, 0);
        drive(E_K2, 8'hF6, 0, 0);
        expect_val("R1", SIG_LRDI, 1); expect_val("R2", SIG_LAIS, 0);
        drive(E_K2, 8'h05, 0, 0);
        expect_val("R1", SIG_LRDI, 0); expect_val("R2", SIG_LAIS, 0);

        // R3 path AIS
        drive(E_H1, 8'hFF, 0, 0);
        drive(E_H2, 8'hFF, 0, 0);
        expect_val("R3", SIG_PAIS, 1);
        drive(E_H1, 8'hFF, 0, 0);
        drive(E_H2, 8'hFE, 0, 0);
        expect_val("R3", SIG_PAIS, 0);
        drive(E_H1, 8'h7F, 0, 0);
        drive(E_H2, 8'hFF, 0, 0);
        expect_val("R3", SIG_PAIS, 0);

        // R4 / R8 path status byte
        drive(E_G1, 8'h38, 0, 0);
        expect_val("R4", SIG_PRDI, 1); expect_val("R8", SIG_PCNT, 3);
        drive(E_G1, 8'h90, 0, 0);
        expect_val("R4", SIG_PRDI, 0); expect_val("R8", SIG_PCNT, 3);
        drive(E_G1, 8'h80, 0, 0);
        expect_val("R8", SIG_PCNT, 11);

        // R7 line growth byte
        drive(E_Z2, 8'd24, 0, 0);
        expect_val("R7", SIG_LCNT, 24);
        drive(E_Z2, 8'd25, 0, 0);
        expect_val("R7", SIG_LCNT, 24);
        drive(E_Z2, 8'hFF, 0, 0);
        expect_val("R7", SIG_LCNT, 24);
        drive(E_Z2, 8'd10, 0, 0);
        expect_val("R7", SIG_LCNT, 34);

        // R10 clear coinciding with a legal count, then clear alone
        drive(E_Z2, 8'd5, 0, 1);
        expect_val("R10", SIG_LCNT, 5); expect_val("R10", SIG_PCNT, 0);
        drive(6'b0, 8'h00, 0, 1);
        expect_val("R10", SIG_LCNT, 0); expect_val("R10", SIG_PCNT, 0);

        // R5 label persistence
        irq_en = 1;
        drive(E_C2, 8'h12, 0, 0);
        drive(E_C2, 8'h12, 0, 0);
        expect_val("R5", SIG_IRQ, 0);
        drive(E_C2, 8'h13, 0, 0);
        drive(E_C2, 8'h12, 0, 0);
        drive(E_C2, 8'h12, 0, 0);
        expect_val("R5", SIG_IRQ, 0);
        drive(E_C2, 8'h00, 0, 0);
        expect_val("R5", SIG_IRQ, 1);

        // R6 latch, clear, set wins over clear
        drive(6'b0, 8'h00, 0, 0);
        expect_val("R6", SIG_IRQ, 1);
        drive(6'b0, 8'h00, 1, 0);
        expect_val("R6", SIG_IRQ, 0);
        drive(E_C2, 8'h12, 1, 0);
        expect_val("R6", SIG_IRQ, 1);
        drive(6'b0, 8'h00, 1, 0);
        expect_val("R6", SIG_IRQ, 0);

        // R5 interrupt disabled
        irq_en = 0;
        drive(E_C2, 8'h13, 0, 0);
        for (int i = 0; i < 4; i++) drive(E_C2, 8'hAA, 0, 0);
        expect_val("R5", SIG_IRQ, 0);

        // R9 saturation of the line total
        drive(6'b0, 8'h00, 0, 1);
        for (int i = 0; i < 2731; i++) drive(E_Z2, 8'd24, 0, 0);
        expect_val("R9", SIG_LCNT, 65535);
        drive(E_Z2, 8'd24, 0, 0);
        expect_val("R9", SIG_LCNT, 65535);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule